// File: doc/BRIEF.md
# Return Address Call Stack

This block holds the return addresses kept in the special register x1 as a last-in, first-out stack of eight entries. It replaces a plain register: writing x1 pushes a value and reading x1 takes the top value off the stack. Neither change touches the stored entries right away. A read or a write only marks a pending pop or a pending push. The stack changes only when the surrounding pipeline signals that the instruction commits, and an abort throws all pending work away.

The block checks each instruction for misuse. A read of an empty stack is an underflow. A write to a full stack, with no read of x1 in the same instruction, is an overflow. Either case raises the call stack error, which the block presents as a single line and as bit 2 of an eight-bit error vector. An instruction that carries an error cannot commit. Only an abort clears the error. A side port shows the committed depth and the top entry at all times and never changes any state.

The controller is a three-state machine. In IDLE no access is pending. In PENDING a pop, a push or both are waiting for the instruction to end. In FAULT an error is latched. The transitions are:
- IDLE→PENDING on a legal read or write.
- IDLE/PENDING→FAULT on a read while empty, or on a commit with an overflow pending.
- PENDING→IDLE on a clean commit, which applies the pending pop and then the pending push, or on an abort.
- FAULT→IDLE on an abort.

If commit or abort is high, the read and write strobes in that same cycle do not count. When commit and abort are both high, abort takes precedence.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty, the depth reads 0, the error line is low, the error vector is 0 and the read data is 0.
- R2: A write of x1 pushes its data only when the instruction commits. Before the commit the depth is unchanged. After the commit the depth is one higher and the top entry equals the written value.
- R3: A read of x1 on a non-empty stack returns the top entry combinationally, and the entry is popped on commit. Several reads within one instruction all return the same value and cause a single pop.
- R4: A read of x1 on an empty stack returns 0 and raises the call stack error.
- R5: A write of x1 while the stack holds 8 entries, with no read of x1 in the same instruction, raises the call stack error before the instruction ends.
- R6: A read and a write of x1 in the same instruction replace the top entry on commit (the pop is applied before the push). This holds on a full stack, where it raises no error.
- R7: The call stack error appears on the error line and on bit 2 of the error vector, and all other bits of the vector are 0. A commit while the error is raised leaves the stack unchanged and keeps the error.
- R8: An abort discards the pending pop, the pending push and the error, and leaves the committed stack unchanged.
- R9: The peek outputs show the committed depth and top entry (0 when empty) without altering any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe for x1 in the current instruction |
| wr_en | input | 1 | Write strobe for x1 in the current instruction |
| wr_data | input | WIDTH | Value to push |
| commit | input | 1 | The current instruction commits |
| abort | input | 1 | The current instruction is abandoned |
| rd_data | output | WIDTH | Top entry, or 0 when empty |
| err | output | 1 | Call stack error for the current instruction |
| err_bits | output | 8 | Error vector with the call stack error on bit 2 |
| dbg_depth | output | $clog2(DEPTH+1) | Committed number of entries |
| dbg_top | output | WIDTH | Committed top entry, or 0 when empty |

## Verification
The stack is driven with separate write-only, read-only and read-plus-write instructions. These distinguish a push, a pop and a replace by the depth and top entry seen after commit. Repeated reads within one instruction show whether the pop is counted once or several times. Reads and writes at the two extremes of occupancy (empty and eight entries) tell a legal access apart from an underflow, an overflow and the full-stack replace. Each of those is then resolved once with commit and once with abort, which separates deferred effects from discarded ones.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_FAULT = 2'd2
    } ras_state_e;

    localparam int ERR_VEC_W  = 8;
    localparam int CS_ERR_POS = 2;
endpackage

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic             do_pop,
    input  logic             do_push,
    input  logic [WIDTH-1:0] push_val,
    output logic [DW-1:0]    depth,
    output logic [WIDTH-1:0] top
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] slots [DEPTH];
    logic [IW-1:0]    top_idx;
    logic [IW-1:0]    wr_idx;

    assign top_idx = IW'(depth - DW'(1));
    assign wr_idx  = do_pop ? top_idx : IW'(depth);
    assign top     = (depth == '0) ? '0 : slots[top_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic we;
        assign we = apply && do_push && (wr_idx == IW'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  slots[g] <= '0;
            else if (we) slots[g] <= push_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (apply) begin
            unique case ({do_push, do_pop})
                2'b10:   depth <= depth + DW'(1);
                2'b01:   depth <= depth - DW'(1);
                default: depth <= depth;
            endcase
        end
    end

    // R2
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(DEPTH));

    // R2
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && do_push && !do_pop) |=> depth == $past(depth) + DW'(1));

    // R6
    replace_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && do_push && do_pop) |=> $stable(depth));
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             commit,
    input  logic             abort,
    input  logic [DW-1:0]    depth,
    output logic             apply,
    output logic             do_pop,
    output logic             do_push,
    output logic [WIDTH-1:0] push_val,
    output logic             err
);
    ras_state_e       state_q, state_d;
    logic             pop_q, pop_d;
    logic             push_q, push_d;
    logic [WIDTH-1:0] val_q, val_d;
    logic             empty, full, ovf_pend, udf_now, access;

    assign empty    = (depth == '0);
    assign full     = (depth == DW'(DEPTH));
    assign ovf_pend = push_q && !pop_q && full;
    assign udf_now  = rd_en && empty;
    assign access   = rd_en || wr_en;

    always_comb begin
        state_d = state_q;
        pop_d   = pop_q;
        push_d  = push_q;
        val_d   = val_q;
        unique case (state_q)
            ST_IDLE, ST_PEND: begin
                if (abort || commit) begin
                    pop_d   = 1'b0;
                    push_d  = 1'b0;
                    state_d = (!abort && ovf_pend) ? ST_FAULT : ST_IDLE;
                end else if (udf_now) begin
                    pop_d   = 1'b0;
                    push_d  = 1'b0;
                    state_d = ST_FAULT;
                end else if (access) begin
                    if (rd_en) pop_d = 1'b1;
                    if (wr_en) begin
                        push_d = 1'b1;
                        val_d  = wr_data;
                    end
                    state_d = ST_PEND;
                end
            end
            ST_FAULT: begin
                if (abort) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pop_q   <= 1'b0;
            push_q  <= 1'b0;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            pop_q   <= pop_d;
            push_q  <= push_d;
            val_q   <= val_d;
        end
    end

    always_comb begin
        apply    = (state_q == ST_PEND) && commit && !abort && !ovf_pend;
        do_pop   = pop_q;
        do_push  = push_q;
        push_val = val_q;
        err      = (state_q == ST_FAULT) || ((state_q == ST_PEND) && ovf_pend);
    end

    // R8
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE) && !err);

    // R4
    underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !commit && !abort) |=> err);

    // R5
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && push_q && !pop_q && full) |-> err);
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [WIDTH-1:0]     wr_data,
    input  logic                 commit,
    input  logic                 abort,
    output logic [WIDTH-1:0]     rd_data,
    output logic                 err,
    output logic [ERR_VEC_W-1:0] err_bits,
    output logic [DW-1:0]        dbg_depth,
    output logic [WIDTH-1:0]     dbg_top
);
    logic             apply, do_pop, do_push;
    logic [WIDTH-1:0] push_val;
    logic [DW-1:0]    depth;
    logic [WIDTH-1:0] top;

    ras_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .commit(commit), .abort(abort), .depth(depth),
        .apply(apply), .do_pop(do_pop), .do_push(do_push),
        .push_val(push_val), .err(err)
    );

    ras_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .apply(apply), .do_pop(do_pop),
        .do_push(do_push), .push_val(push_val), .depth(depth), .top(top)
    );

    always_comb begin
        err_bits             = '0;
        err_bits[CS_ERR_POS] = err;
    end

    assign rd_data   = top;
    assign dbg_depth = depth;
    assign dbg_top   = top;

    // R7
    err_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !abort && err) |=> $stable(dbg_depth) && $stable(dbg_top));

    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_depth == '0) |-> (rd_data == '0));
endmodule

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int WIDTH = 32;
    localparam int DW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_en = 1'b0, wr_en = 1'b0, commit = 1'b0, abort = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data, dbg_top;
    logic             err;
    logic [7:0]       err_bits;
    logic [DW-1:0]    dbg_depth;

    int total = 0;
    int bad = 0;
    logic [WIDTH-1:0] s_rd;
    logic             s_err;
    logic [7:0]       s_bits;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ret_addr_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .commit(commit), .abort(abort),
        .rd_data(rd_data), .err(err), .err_bits(err_bits),
        .dbg_depth(dbg_depth), .dbg_top(dbg_top)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input int d, input logic [WIDTH-1:0] t, input logic e);
        chk(dbg_depth == DW'(d), req, dbg_depth, d);
        chk(dbg_top == t, req, dbg_top, t);
        chk(err == e, req, err, e);
    endtask

    // one cycle of strobes; comb outputs captured mid-cycle, state seen after return
    task automatic step(input logic r, input logic w, input logic [WIDTH-1:0] d,
                        input logic c, input logic a);
        @(negedge clk);
        rd_en = r; wr_en = w; wr_data = d; commit = c; abort = a;
        #1;
        s_rd = rd_data; s_err = err; s_bits = err_bits;
        @(posedge clk);
        @(negedge clk);
        rd_en = 0; wr_en = 0; wr_data = '0; commit = 0; abort = 0;
        #1;
    endtask

    task automatic push_commit(input logic [WIDTH-1:0] v);
        step(0, 1, v, 0, 0);
        step(0, 0, '0, 1, 0);
    endtask

    task automatic t_reset();
        chk_state("R1", 0, '0, 0);
        chk(err_bits == 8'h00, "R1", err_bits, 0);
        chk(rd_data == '0, "R1", rd_data, 0);
    endtask

    task automatic t_push();
        step(0, 1, 32'h100, 0, 0);
        chk(dbg_depth == 0, "R2 deferred", dbg_depth, 0);
        step(0, 0, '0, 1, 0);
        chk_state("R2", 1, 32'h100, 0);
        push_commit(32'h200);
        push_commit(32'h300);
        chk_state("R2", 3, 32'h300, 0);
        chk_state("R9 peek stable", 3, 32'h300, 0);
    endtask

    task automatic t_pop();
        step(1, 0, '0, 0, 0);
        chk(s_rd == 32'h300, "R3 read", s_rd, 32'h300);
        step(1, 0, '0, 0, 0);
        chk(s_rd == 32'h300, "R3 reread", s_rd, 32'h300);
        chk(dbg_depth == 3, "R3 deferred", dbg_depth, 3);
        step(0, 0, '0, 1, 0);
        chk_state("R3 single pop", 2, 32'h200, 0);
    endtask

    task automatic t_abort();
        step(1, 1, 32'h999, 0, 0);
        step(0, 0, '0, 0, 1);
        chk_state("R8", 2, 32'h200, 0);
    endtask

    task automatic t_replace();
        step(1, 1, 32'hAAA, 0, 0);
        chk(s_rd == 32'h200, "R6 read", s_rd, 32'h200);
        step(0, 0, '0, 1, 0);
        chk_state("R6", 2, 32'hAAA, 0);
        step(1, 0, '0, 0, 0); step(0, 0, '0, 1, 0);
        step(1, 0, '0, 0, 0); step(0, 0, '0, 1, 0);
        chk_state("R3 drain", 0, '0, 0);
    endtask

    task automatic t_underflow();
        step(1, 0, '0, 0, 0);
        chk(s_rd == '0, "R4 data", s_rd, 0);
        chk(err == 1'b1, "R4 err", err, 1);
        chk(err_bits == 8'h04, "R7 bit2", err_bits, 8'h04);
        step(0, 0, '0, 1, 0);
        chk_state("R7 commit blocked", 0, '0, 1);
        step(0, 0, '0, 0, 1);
        chk_state("R8 clear", 0, '0, 0);
    endtask

    task automatic t_overflow();
        for (int i = 1; i <= DEPTH; i++) push_commit(WIDTH'(i * 16 + 1));
        chk_state("R2 full", 8, 32'h81, 0);
        step(0, 1, 32'hBAD, 0, 0);
        chk(err == 1'b1, "R5", err, 1);
        chk(err_bits == 8'h04, "R7 bit2", err_bits, 8'h04);
        step(0, 0, '0, 1, 0);
        chk_state("R7 commit blocked", 8, 32'h81, 1);
        step(0, 0, '0, 0, 1);
        chk_state("R8", 8, 32'h81, 0);
    endtask

    task automatic t_full_replace();
        step(0, 1, 32'hC0DE, 0, 0);
        step(1, 0, '0, 0, 0);
        chk(s_rd == 32'h81, "R6 read", s_rd, 32'h81);
        chk(err == 1'b0, "R6 no err", err, 0);
        step(0, 0, '0, 1, 0);
        chk_state("R6 full", 8, 32'hC0DE, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_push();
        t_pop();
        t_abort();
        t_replace();
        t_underflow();
        t_overflow();
        t_full_replace();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule